// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

The block turns a reference clock into a steady one-microsecond time base. The reference can run at one of several rates. A fractional prescaler adds a programmed step to an accumulator on every reference cycle. Whenever the accumulator reaches the programmed modulus, the prescaler emits a one-cycle tick. A free-running counter advances by one on each tick. Other timers can use the tick as their enable.

Software uses a plain single-cycle register port. One offset returns the running counter. A second offset holds the prescaler ratio, and that offset can be both written and read. Because the ratio reads back, software can save it before power is removed and restore it afterwards. Writing the ratio restarts the accumulator, so the new ratio applies from a known phase.

Top module: `usec_tick_timer`

## Requirements
- R1: After reset the counter reads 0, the tick output is low and the ratio register reads 0x0000000b.
- R2: The ratio word holds (step - 1) in bits [15:8] and (modulus - 1) in bits [7:0]. When step < modulus, the N cycles that follow a ratio write contain exactly floor(N*step/modulus) ticks.
- R3: A write to the ratio register clears the accumulator, and the tick is low in the cycle after that write.
- R4: When step >= modulus, the tick is high in every cycle after the restart cycle.
- R5: The counter rises by exactly one in the cycle after a tick and otherwise holds its value.
- R6: The counter wraps from its all-ones value to zero. Its width is CNT_W, 32 by default.
- R7: Reads are combinational. Offset 0x10 returns the counter, and offset 0x14 returns the ratio word zero-extended to 32 bits. Any other offset returns 0.
- R8: Only a write to offset 0x14 changes the ratio, and it takes only bits [15:0]. Writes to other offsets change nothing and do not restart the accumulator.
- R9: The standard ratio words give a 1 MHz average. These are 0x000b at 12 MHz, 0x000c at 13 MHz, 0x0019 at 26 MHz and 0x045f at 19.2 MHz (5/96).
- R10: With ratio word 0x045f, consecutive ticks are either 19 or 20 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| tick_o | output | 1 | One-cycle microsecond tick |

## Verification
Counter wrap-around is the hardest case to reach from the ports. At 32 bits it needs billions of ticks. The bench therefore builds a second instance with an 8-bit counter and a 1:1 ratio, and watches it pass from 255 to 0 within a few hundred cycles. The 19.2 MHz ratio is checked in two ways. The bench counts the ticks over 1920 cycles, and it also records the shortest and longest gap between ticks, which shows that the fractional spreading is even.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;
    localparam int FIELD_W = 8;
    localparam int CFG_W   = 2 * FIELD_W;
    localparam int DATA_W  = 32;
    localparam int SUM_W   = FIELD_W + 2;

    typedef struct packed {
        logic [FIELD_W-1:0] step_m1;
        logic [FIELD_W-1:0] mod_m1;
    } ratio_t;
endpackage

// File: rtl/usec_ratio_reg.sv
module usec_ratio_reg
    import usec_tick_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_VAL = 16'h000b
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_val,
    output ratio_t           ratio,
    output logic             restart
);
    typedef struct packed {
        ratio_t ratio;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ratio = ratio_t'(wr_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ratio <= ratio_t'(RESET_VAL);
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio   = st_q.ratio;
    assign restart = wr_en;
endmodule

// File: rtl/usec_frac_tick.sv
module usec_frac_tick
    import usec_tick_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t ratio,
    input  logic   restart,
    output logic   tick
);
    typedef struct packed {
        logic [SUM_W-1:0] acc;
        logic             tick;
    } state_t;

    state_t st_d, st_q;

    logic [SUM_W-1:0] step_w;
    logic [SUM_W-1:0] mod_w;
    logic [SUM_W-1:0] sum_w;

    always_comb begin
        step_w = SUM_W'(ratio.step_m1) + SUM_W'(1);
        mod_w  = SUM_W'(ratio.mod_m1) + SUM_W'(1);
        sum_w  = st_q.acc + step_w;
        st_d   = st_q;
        if (restart) begin
            st_d.acc  = '0;
            st_d.tick = 1'b0;
        end else if (step_w >= mod_w) begin
            st_d.acc  = '0;
            st_d.tick = 1'b1;
        end else if (sum_w >= mod_w) begin
            st_d.acc  = sum_w - mod_w;
            st_d.tick = 1'b1;
        end else begin
            st_d.acc  = sum_w;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc  <= '0;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(tick);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/usec_tick_timer.sv
module usec_tick_timer
    import usec_tick_pkg::*;
#(
    parameter int                CNT_W     = 32,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFF_COUNT = 8'h10,
    parameter logic [ADDR_W-1:0] OFF_CFG   = 8'h14,
    parameter logic [CFG_W-1:0]  CFG_RESET = 16'h000b
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tick_o
);
    ratio_t           cfg_val;
    logic             cfg_wr;
    logic             acc_restart;
    logic [CNT_W-1:0] cnt_val;
    logic             unused_wdata_hi;

    assign cfg_wr          = reg_we && (reg_addr == OFF_CFG);
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CFG_W];

    usec_ratio_reg #(
        .RESET_VAL (CFG_RESET)
    ) u_ratio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_val  (reg_wdata[CFG_W-1:0]),
        .ratio   (cfg_val),
        .restart (acc_restart)
    );

    usec_frac_tick u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio   (cfg_val),
        .restart (acc_restart),
        .tick    (tick_o)
    );

    usec_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_o),
        .count (cnt_val)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_COUNT) begin
            reg_rdata[CNT_W-1:0] = cnt_val;
        end else if (reg_addr == OFF_CFG) begin
            reg_rdata[CFG_W-1:0] = cfg_val;
        end
    end
endmodule

// File: rtl/usec_tick_timer_chk.sv
module usec_tick_timer_chk
    import usec_tick_pkg::*;
#(
    parameter int                CNT_W   = 32,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] OFF_CFG = 8'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              tick_o,
    input logic [CNT_W-1:0]  count,
    input logic [CFG_W-1:0]  cfg
);
    // R3: the restart cycle never carries a tick
    p_cfg_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_CFG) |=> !tick_o);

    // R5: each tick advances the counter by one
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (count == $past(count) + CNT_W'(1)));

    // R5: no tick, no change
    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> $stable(count));

    // R8: a ratio write loads the low half of the data
    p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_CFG) |=> (cfg == $past(reg_wdata[CFG_W-1:0])));

    // R8: any other cycle leaves the ratio untouched
    p_cfg_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == OFF_CFG) |=> $stable(cfg));
endmodule

bind usec_tick_timer usec_tick_timer_chk #(
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .OFF_CFG (OFF_CFG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tick_o    (tick_o),
    .count     (cnt_val),
    .cfg       (cfg_val)
);

// File: tb/tb_usec_tick_timer.sv
module tb_usec_tick_timer;
    localparam logic [7:0] A_CNT = 8'h10;
    localparam logic [7:0] A_CFG = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = A_CNT;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_o;
    logic [31:0] rdata_w;
    logic        tick_w;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    usec_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_o(tick_o)
    );

    usec_tick_timer #(.CNT_W(8)) dut_w (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_w), .tick_o(tick_w)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = A_CNT; reg_wdata = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        do_read(A_CNT, v);
        chk(v == 0, "R1", "count after reset", v, 0);
        do_read(A_CFG, v);
        chk(v == 32'h0000000b, "R1", "ratio after reset", v, 32'h0b);
        chk(tick_o == 1'b0, "R1", "tick after reset", tick_o, 0);
    endtask

    task automatic run_ratio(input logic [15:0] cfg, input int n, input string req,
                             input bit gap_chk);
        logic [31:0] v, prev_c, cur;
        logic        prev_t;
        int step, modu, ticks, bad, last, gmin, gmax, expn;
        step = int'(cfg[15:8]) + 1;
        modu = int'(cfg[7:0]) + 1;
        do_write(A_CFG, {16'h0000, cfg});
        chk(tick_o == 1'b0, "R3", "tick after ratio write", tick_o, 0);
        do_read(A_CFG, v);
        chk(v == {16'h0, cfg}, "R7", "ratio readback", v, cfg);
        do_read(A_CNT, prev_c);
        prev_t = tick_o;
        ticks = 0; bad = 0; last = 0; gmin = 1000; gmax = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            #1;
            cur = reg_rdata;
            if (cur != prev_c + 32'(prev_t)) bad++;
            if (tick_o) begin
                ticks++;
                if (last > 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
            end
            prev_c = cur;
            prev_t = tick_o;
        end
        chk(bad == 0, "R5", "counter steps per tick", bad, 0);
        expn = (step >= modu) ? n : (n * step) / modu;
        chk(ticks == expn, req, "tick total", ticks, expn);
        if (gap_chk) begin
            chk(gmin == 19, "R10", "shortest gap", gmin, 19);
            chk(gmax == 20, "R10", "longest gap", gmax, 20);
        end
    endtask

    task automatic t_ignored_writes;
        logic [31:0] c0, v;
        do_read(A_CNT, c0);
        do_write(A_CNT, 32'h12345678);
        do_read(A_CNT, v);
        chk(v == c0 + 2, "R8", "counter after write to its offset", v, c0 + 2);
        do_read(A_CFG, v);
        chk(v == 32'h0, "R8", "ratio after counter write", v, 0);
        do_write(8'h20, 32'h00000707);
        chk(tick_o == 1'b1, "R8", "no restart on stray write", tick_o, 1);
        do_read(A_CFG, v);
        chk(v == 32'h0, "R8", "ratio after stray write", v, 0);
        do_read(8'h20, v);
        chk(v == 32'h0, "R7", "unmapped read", v, 0);
        do_write(A_CFG, 32'hdead0203);
        do_read(A_CFG, v);
        chk(v == 32'h00000203, "R8", "upper write bits dropped", v, 32'h203);
        reg_addr = A_CNT;
    endtask

    task automatic t_wrap;
        logic [7:0] prev, cur;
        logic       prev_t;
        int bad, hi_bad;
        bit saw_wrap;
        do_write(A_CFG, 32'h0);
        reg_addr = A_CNT;
        #1;
        prev = rdata_w[7:0];
        prev_t = tick_w;
        bad = 0; hi_bad = 0; saw_wrap = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            #1;
            cur = rdata_w[7:0];
            if (rdata_w[31:8] != 0) hi_bad++;
            if (cur != prev + 8'(prev_t)) bad++;
            if (prev == 8'hff && cur == 8'h00) saw_wrap = 1;
            prev = cur;
            prev_t = tick_w;
        end
        chk(saw_wrap, "R6", "narrow counter wrapped to zero", saw_wrap, 1);
        chk(bad == 0, "R6", "narrow counter modulo steps", bad, 0);
        chk(hi_bad == 0, "R7", "narrow counter zero-extended", hi_bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_ratio(16'h000b, 1200, "R9", 1'b0);
        run_ratio(16'h000c, 1300, "R9", 1'b0);
        run_ratio(16'h0019, 2600, "R9", 1'b0);
        run_ratio(16'h045f, 1920, "R9", 1'b1);
        run_ratio(16'h0203, 100, "R2", 1'b0);
        run_ratio(16'h0406, 140, "R2", 1'b0);
        run_ratio(16'h0000, 50, "R4", 1'b0);
        t_ignored_writes();
        run_ratio(16'h0501, 40, "R4", 1'b0);
        run_ratio(16'hff00, 40, "R4", 1'b0);
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule